// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block holds pending interrupt sources sorted into priority levels and decides, every cycle, whether the processor should take an interrupt. Each level owns a 64-bit source vector. A per-level pending bit is set when any source in that level is posted, and it stays set until the level's last source is cleared. Sources are posted and cleared through two independent ports, each carrying a level and a source index. A clear-all input empties every level at once.

The decision merges two request groups into a single priority and a 32-bit summary mask. The first group is a software request vector covering levels 1 to 15. The second group is the pending bits of the external levels 16 to 31. An interrupt is raised only when the merged priority is above the core's current priority level and the low program-counter bits are aligned. The priority and summary of a raised interrupt are latched. They stay latched until the core commits them, which copies them into an interrupt-status register and an interrupt-ID register.

Top module: `lvlint_ctrl`

## Requirements
- R1: A post with an in-range level L (0 to 31) and index X sets source bit X of level L and marks level L pending from the next cycle.
- R2: A clear with level L and index X drops source bit X. Level L stays pending while any other source bit of L is set, and stops being pending once its vector is empty.
- R3: Clear-all empties every level in one cycle and wins over a post in the same cycle.
- R4: Software request bit k (k = 0..14) stands for level k+1. It sets summary bit k+1 and gives priority k+1. Each pending external level i (16..31) sets summary bit i and gives priority i. The highest contributor wins, and any external level beats all software levels. Summary bit 0 is always zero.
- R5: An interrupt is eligible only when at least one level (0..31) is pending and `pc_low_i` equals 2'b00.
- R6: `take_o` is high only when R5 holds, the merged priority is nonzero, and it is strictly greater than `cur_ipl_i`.
- R7: When `take_o` is high and nothing is latched, the priority and summary are latched on that edge and `cap_valid_o` rises. While latched, the values hold. A commit copies the summary to `isr_o` and the priority to `intid_o` on the edge, and clears `cap_valid_o`.
- R8: A commit while nothing is latched leaves `isr_o` and `intid_o` unchanged and pulses `commit_err_o` high for one cycle after the edge.
- R9: A post or clear whose level is 32 or above changes no state.
- R10: A post and a clear aimed at the same level and index in the same cycle leave the bit set.
- R11: With `rst_n` low at a clock edge, all vectors, pending bits, latched values, `isr_o`, `intid_o` and `commit_err_o` become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_en_i | input | 1 | Post request |
| post_lvl_i | input | 6 | Level of the post |
| post_idx_i | input | 6 | Source index of the post |
| clr_en_i | input | 1 | Clear request |
| clr_lvl_i | input | 6 | Level of the clear |
| clr_idx_i | input | 6 | Source index of the clear |
| clr_all_i | input | 1 | Empty every level |
| sw_req_i | input | 15 | Software requests, bit k is level k+1 |
| cur_ipl_i | input | 5 | Current priority level of the core |
| pc_low_i | input | 2 | Two low program-counter bits |
| commit_i | input | 1 | Core acknowledges the latched interrupt |
| take_o | output | 1 | Raise interrupt now |
| new_ipl_o | output | 5 | Merged priority |
| new_summary_o | output | 32 | Merged summary mask |
| cap_valid_o | output | 1 | A priority and summary are latched |
| isr_o | output | 32 | Committed summary |
| intid_o | output | 5 | Committed priority |
| commit_err_o | output | 1 | Commit arrived with nothing latched |

## Verification
The assertions check the state transitions on every cycle. A post sets its level's pending bit. Clear-all empties the pending bits. An out-of-range post with no other request leaves them stable. A simultaneous post and clear keeps the bit. A commit moves the latched pair into the ID registers, an unlatched commit flags an error and holds the registers, and a latched pair stays stable until it is committed. The merge itself can only be shown by the bench's reference model over chosen and random patterns. That covers software against external precedence, the strict-greater test against the current level, the alignment gate, and eligibility coming from low levels that add no priority.

// File: rtl/lvlint_pkg.sv
// Shared constants and types for the leveled interrupt controller.
// Assumes: a single clock domain; all users import this package.
package lvlint_pkg;
    localparam int DEF_NUM_LEVELS = 32;
    localparam int DEF_SRC_W      = 64;
    localparam int DEF_SW_LO      = 1;
    localparam int DEF_SW_HI      = 15;
    localparam int DEF_EXT_LO     = 16;
    localparam int DEF_EXT_HI     = 31;

    // Action taken by the commit port in a cycle.
    typedef enum logic [1:0] {
        CM_IDLE   = 2'd0,
        CM_WRITE  = 2'd1,
        CM_REJECT = 2'd2
    } cmt_op_e;
endpackage

// File: rtl/lvlint_store.sv
// Per-level source vectors and pending bits.
// A post sets one source bit, and a clear drops one. The post wins on the
// same bit, and clear-all wins over both. A level's pending bit is the OR of
// its next vector, registered. Levels at or above NUM_LEVELS are dropped.
// Assumes: post and clear indices are always inside the vector width.
module lvlint_store #(
    parameter int NUM_LEVELS = lvlint_pkg::DEF_NUM_LEVELS,
    parameter int SRC_W      = lvlint_pkg::DEF_SRC_W,
    parameter int LVL_IN_W   = $clog2(NUM_LEVELS) + 1,
    parameter int IDX_W      = $clog2(SRC_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  post_en_i,
    input  logic [LVL_IN_W-1:0]   post_lvl_i,
    input  logic [IDX_W-1:0]      post_idx_i,
    input  logic                  clr_en_i,
    input  logic [LVL_IN_W-1:0]   clr_lvl_i,
    input  logic [IDX_W-1:0]      clr_idx_i,
    input  logic                  clr_all_i,
    output logic [NUM_LEVELS-1:0] status_o
);
    localparam logic [LVL_IN_W-1:0] LVL_LIMIT = LVL_IN_W'(NUM_LEVELS);

    logic post_ok;
    logic clr_ok;

    // Qualify each request against the level range.
    assign post_ok = post_en_i && (post_lvl_i < LVL_LIMIT);
    assign clr_ok  = clr_en_i  && (clr_lvl_i  < LVL_LIMIT);

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
        logic [SRC_W-1:0] vec_q;
        logic [SRC_W-1:0] set_m;
        logic [SRC_W-1:0] clr_m;
        logic [SRC_W-1:0] nxt;
        logic             pend_q;

        // Decode the one-hot set and clear masks for this level.
        assign set_m = (post_ok && post_lvl_i == LVL_IN_W'(l)) ? (SRC_W'(1) << post_idx_i) : '0;
        assign clr_m = (clr_ok  && clr_lvl_i  == LVL_IN_W'(l)) ? (SRC_W'(1) << clr_idx_i)  : '0;
        // Clear first, then post, so a post wins on a shared bit.
        assign nxt   = clr_all_i ? '0 : ((vec_q & ~clr_m) | set_m);

        // Register the vector and its pending flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q  <= '0;
                pend_q <= 1'b0;
            end else begin
                vec_q  <= nxt;
                pend_q <= |nxt;
            end
        end

        assign status_o[l] = pend_q;

        // R10: a post to this level leaves its bit set even with a matching clear.
        assert_post_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (post_ok && post_lvl_i == LVL_IN_W'(l) && !clr_all_i)
            |=> vec_q[$past(post_idx_i)]);
    end

    // R1: an in-range post marks its level pending on the next cycle.
    assert_post_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (post_ok && !clr_all_i)
        |=> status_o[$past(post_lvl_i[LVL_IN_W-2:0])]);

    // R3: clear-all leaves no level pending.
    assert_clear_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all_i |=> (status_o == '0));

    // R9: an out-of-range post alone changes no pending bit.
    assert_oor_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (post_en_i && !post_ok && !clr_en_i && !clr_all_i) |=> $stable(status_o));
endmodule

// File: rtl/lvlint_prio.sv
// Merges software requests and pending external levels into one priority
// and summary. It then gates the interrupt on the pending state, program
// counter alignment and the current level.
// Assumes: SW_LO >= 1, and the external range lies above the software range.
module lvlint_prio #(
    parameter int NUM_LEVELS = lvlint_pkg::DEF_NUM_LEVELS,
    parameter int SW_LO      = lvlint_pkg::DEF_SW_LO,
    parameter int SW_HI      = lvlint_pkg::DEF_SW_HI,
    parameter int EXT_LO     = lvlint_pkg::DEF_EXT_LO,
    parameter int EXT_HI     = lvlint_pkg::DEF_EXT_HI,
    parameter int PRIO_W     = $clog2(NUM_LEVELS),
    parameter int SW_N       = SW_HI - SW_LO + 1
) (
    input  logic [NUM_LEVELS-1:0] status_i,
    input  logic [SW_N-1:0]       sw_req_i,
    input  logic [PRIO_W-1:0]     cur_ipl_i,
    input  logic [1:0]            pc_low_i,
    output logic                  take_o,
    output logic [PRIO_W-1:0]     ipl_o,
    output logic [NUM_LEVELS-1:0] summary_o
);
    // Scan software then external contributors; a later contributor overrides.
    always_comb begin
        ipl_o     = '0;
        summary_o = '0;
        for (int k = 0; k < SW_N; k++) begin
            if (sw_req_i[k]) begin
                ipl_o                = PRIO_W'(k + 1);
                summary_o[SW_LO + k] = 1'b1;
            end
        end
        for (int i = EXT_LO; i <= EXT_HI; i++) begin
            if (status_i[i]) begin
                ipl_o        = PRIO_W'(i);
                summary_o[i] = 1'b1;
            end
        end
    end

    // Raise only when something is pending, the PC is aligned and the level is higher.
    assign take_o = (|status_i) && (pc_low_i == 2'b00) &&
                    (ipl_o != '0) && (ipl_o > cur_ipl_i);
endmodule

// File: rtl/lvlint_commit.sv
// Latches the priority and summary of a raised interrupt and holds them
// until a commit copies them into the status and ID registers. A commit
// with nothing latched is rejected and reported for one cycle.
// Assumes: take_i, ipl_i and summary_i come straight from the resolver.
module lvlint_commit
    import lvlint_pkg::*;
#(
    parameter int NUM_LEVELS = DEF_NUM_LEVELS,
    parameter int PRIO_W     = $clog2(NUM_LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take_i,
    input  logic [PRIO_W-1:0]     ipl_i,
    input  logic [NUM_LEVELS-1:0] summary_i,
    input  logic                  commit_i,
    output logic                  valid_o,
    output logic [NUM_LEVELS-1:0] isr_o,
    output logic [PRIO_W-1:0]     intid_o,
    output logic                  err_o
);
    cmt_op_e               op;
    logic [PRIO_W-1:0]     cap_ipl_q;
    logic [NUM_LEVELS-1:0] cap_sum_q;

    // Classify the commit port for this cycle.
    always_comb begin
        if (!commit_i)    op = CM_IDLE;
        else if (valid_o) op = CM_WRITE;
        else              op = CM_REJECT;
    end

    // Hold the latched pair; latch a new one only when empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            cap_ipl_q <= '0;
            cap_sum_q <= '0;
        end else if (op == CM_WRITE) begin
            valid_o   <= 1'b0;
        end else if (take_i && !valid_o) begin
            valid_o   <= 1'b1;
            cap_ipl_q <= ipl_i;
            cap_sum_q <= summary_i;
        end
    end

    // Copy the latched pair into the status and ID registers on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_o   <= '0;
            intid_o <= '0;
        end else if (op == CM_WRITE) begin
            isr_o   <= cap_sum_q;
            intid_o <= cap_ipl_q;
        end
    end

    // Flag a commit that found nothing latched.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= (op == CM_REJECT);
    end

    // R7: a commit with a latched pair moves it into the registers and empties the latch.
    assert_commit_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && valid_o) |=> (!valid_o && isr_o == $past(cap_sum_q) && intid_o == $past(cap_ipl_q)));

    // R7: a latched pair holds until committed.
    assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !commit_i) |=> (valid_o && $stable(cap_ipl_q) && $stable(cap_sum_q)));

    // R8: an unlatched commit flags an error and leaves the registers alone.
    assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !valid_o) |=> (err_o && $stable(isr_o) && $stable(intid_o)));
endmodule

// File: rtl/lvlint_ctrl.sv
// Top of the leveled interrupt controller. It ties the level store, the
// priority resolver and the commit latch together.
// Assumes: inputs are synchronous to clk; rst_n is synchronous, active low.
module lvlint_ctrl
    import lvlint_pkg::*;
#(
    parameter int NUM_LEVELS = DEF_NUM_LEVELS,
    parameter int SRC_W      = DEF_SRC_W,
    parameter int SW_LO      = DEF_SW_LO,
    parameter int SW_HI      = DEF_SW_HI,
    parameter int EXT_LO     = DEF_EXT_LO,
    parameter int EXT_HI     = DEF_EXT_HI,
    parameter int PRIO_W     = $clog2(NUM_LEVELS),
    parameter int LVL_IN_W   = PRIO_W + 1,
    parameter int IDX_W      = $clog2(SRC_W),
    parameter int SW_N       = SW_HI - SW_LO + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  post_en_i,
    input  logic [LVL_IN_W-1:0]   post_lvl_i,
    input  logic [IDX_W-1:0]      post_idx_i,
    input  logic                  clr_en_i,
    input  logic [LVL_IN_W-1:0]   clr_lvl_i,
    input  logic [IDX_W-1:0]      clr_idx_i,
    input  logic                  clr_all_i,
    input  logic [SW_N-1:0]       sw_req_i,
    input  logic [PRIO_W-1:0]     cur_ipl_i,
    input  logic [1:0]            pc_low_i,
    input  logic                  commit_i,
    output logic                  take_o,
    output logic [PRIO_W-1:0]     new_ipl_o,
    output logic [NUM_LEVELS-1:0] new_summary_o,
    output logic                  cap_valid_o,
    output logic [NUM_LEVELS-1:0] isr_o,
    output logic [PRIO_W-1:0]     intid_o,
    output logic                  commit_err_o
);
    logic [NUM_LEVELS-1:0] status;

    lvlint_store #(
        .NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W), .LVL_IN_W(LVL_IN_W), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .post_en_i(post_en_i), .post_lvl_i(post_lvl_i), .post_idx_i(post_idx_i),
        .clr_en_i(clr_en_i), .clr_lvl_i(clr_lvl_i), .clr_idx_i(clr_idx_i),
        .clr_all_i(clr_all_i), .status_o(status)
    );

    lvlint_prio #(
        .NUM_LEVELS(NUM_LEVELS), .SW_LO(SW_LO), .SW_HI(SW_HI),
        .EXT_LO(EXT_LO), .EXT_HI(EXT_HI), .PRIO_W(PRIO_W), .SW_N(SW_N)
    ) u_prio (
        .status_i(status), .sw_req_i(sw_req_i), .cur_ipl_i(cur_ipl_i),
        .pc_low_i(pc_low_i), .take_o(take_o), .ipl_o(new_ipl_o),
        .summary_o(new_summary_o)
    );

    lvlint_commit #(
        .NUM_LEVELS(NUM_LEVELS), .PRIO_W(PRIO_W)
    ) u_commit (
        .clk(clk), .rst_n(rst_n), .take_i(take_o), .ipl_i(new_ipl_o),
        .summary_i(new_summary_o), .commit_i(commit_i), .valid_o(cap_valid_o),
        .isr_o(isr_o), .intid_o(intid_o), .err_o(commit_err_o)
    );
endmodule

// File: tb/lvlint_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model compared against every output each cycle,
// plus directed checks tagged by requirement.
module lvlint_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        post_en_i, clr_en_i, clr_all_i, commit_i;
    logic [5:0]  post_lvl_i, clr_lvl_i, post_idx_i, clr_idx_i;
    logic [14:0] sw_req_i;
    logic [4:0]  cur_ipl_i;
    logic [1:0]  pc_low_i;
    logic        take_o, cap_valid_o, commit_err_o;
    logic [4:0]  new_ipl_o, intid_o;
    logic [31:0] new_summary_o, isr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference model state
    logic [63:0] m_vec [32];
    logic        m_valid, m_err;
    logic [4:0]  m_ci, m_id;
    logic [31:0] m_cs, m_isr;
    logic        e_take;
    logic [4:0]  e_ipl;
    logic [31:0] e_sum;

    always #5 clk = ~clk;

    lvlint_ctrl u_lvlint_ctrl (
        .clk(clk), .rst_n(rst_n),
        .post_en_i(post_en_i), .post_lvl_i(post_lvl_i), .post_idx_i(post_idx_i),
        .clr_en_i(clr_en_i), .clr_lvl_i(clr_lvl_i), .clr_idx_i(clr_idx_i),
        .clr_all_i(clr_all_i), .sw_req_i(sw_req_i), .cur_ipl_i(cur_ipl_i),
        .pc_low_i(pc_low_i), .commit_i(commit_i), .take_o(take_o),
        .new_ipl_o(new_ipl_o), .new_summary_o(new_summary_o),
        .cap_valid_o(cap_valid_o), .isr_o(isr_o), .intid_o(intid_o),
        .commit_err_o(commit_err_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected merge from the model's pending levels and current inputs.
    task automatic model_eval();
        int any;
        any   = 0;
        e_ipl = 0;
        e_sum = 0;
        for (int k = 0; k < 15; k++)
            if (sw_req_i[k]) begin e_ipl = 5'(k + 1); e_sum[k + 1] = 1'b1; end
        for (int l = 0; l < 32; l++) begin
            if (m_vec[l] != 0) begin
                any = 1;
                if (l >= 16) begin e_ipl = 5'(l); e_sum[l] = 1'b1; end
            end
        end
        e_take = (any != 0) && (pc_low_i == 0) && (e_ipl != 0) && (e_ipl > cur_ipl_i);
    endtask

    task automatic model_step();
        logic old_valid;
        if (!rst_n) begin
            for (int l = 0; l < 32; l++) m_vec[l] = 0;
            m_valid = 0; m_err = 0; m_ci = 0; m_cs = 0; m_id = 0; m_isr = 0;
        end else begin
            old_valid = m_valid;
            m_err = commit_i && !old_valid;
            if (commit_i && old_valid) begin m_isr = m_cs; m_id = m_ci; m_valid = 0; end
            if (e_take && !old_valid) begin m_cs = e_sum; m_ci = e_ipl; m_valid = 1; end
            if (clr_all_i) begin
                for (int l = 0; l < 32; l++) m_vec[l] = 0;
            end else begin
                if (clr_en_i && clr_lvl_i < 32) m_vec[clr_lvl_i[4:0]][clr_idx_i] = 1'b0;
                if (post_en_i && post_lvl_i < 32) m_vec[post_lvl_i[4:0]][post_idx_i] = 1'b1;
            end
        end
    endtask

    // One clock: compare all outputs, advance DUT and model, return at negedge.
    task automatic cycle();
        #1;
        model_eval();
        chk("R6 take", take_o, e_take);
        chk("R4 ipl", new_ipl_o, e_ipl);
        chk("R4 summary", new_summary_o, e_sum);
        chk("R7 valid", cap_valid_o, m_valid);
        chk("R7 isr", isr_o, m_isr);
        chk("R7 intid", intid_o, m_id);
        chk("R8 err", commit_err_o, m_err);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        post_en_i = 0; clr_en_i = 0; clr_all_i = 0; commit_i = 0;
    endtask

    task automatic post(input int lvl, input int idx);
        post_en_i = 1; post_lvl_i = 6'(lvl); post_idx_i = 6'(idx);
    endtask

    task automatic clr(input int lvl, input int idx);
        clr_en_i = 1; clr_lvl_i = 6'(lvl); clr_idx_i = 6'(idx);
    endtask

    initial begin
        rst_n = 0; idle();
        post_lvl_i = 0; post_idx_i = 0; clr_lvl_i = 0; clr_idx_i = 0;
        sw_req_i = 0; cur_ipl_i = 0; pc_low_i = 0;
        @(negedge clk);
        repeat (3) cycle();
        #1;
        chk("R11 reset isr", isr_o, 0);
        chk("R11 reset intid", intid_o, 0);
        chk("R11 reset valid", cap_valid_o, 0);
        chk("R11 reset take", take_o, 0);
        rst_n = 1;
        cycle();

        // R1: external post raises priority 20
        post(20, 5); cycle(); idle(); #1;
        chk("R1 pending", new_summary_o[20], 1);
        chk("R6 take on 20", take_o, 1);
        chk("R4 ipl 20", new_ipl_o, 20);
        cycle();
        chk("R7 latched", cap_valid_o, 1);
        commit_i = 1; cycle(); idle(); #1;
        chk("R7 isr bit", isr_o[20], 1);
        chk("R7 intid", intid_o, 20);
        chk("R7 valid clear", cap_valid_o, 0);
        // Unlatched commit while take is high: error and fresh latch
        commit_i = 1; cycle(); idle(); #1;
        chk("R8 error pulse", commit_err_o, 1);
        chk("R8 isr kept", isr_o, 32'h0010_0000);
        cycle();

        // R2: level stays pending until its last source goes
        post(20, 9); cycle(); idle();
        clr(20, 5); cycle(); idle(); #1;
        chk("R2 still pending", new_summary_o[20], 1);
        clr(20, 9); cycle(); idle(); #1;
        chk("R2 emptied", new_summary_o[20], 0);
        chk("R2 no take", take_o, 0);

        // R4/R5/R6: low level gives eligibility, software gives priority
        post(3, 0); cycle(); idle(); #1;
        chk("R6 zero priority", take_o, 0);
        sw_req_i = 15'h0040; #1;
        chk("R4 sw ipl 7", new_ipl_o, 7);
        chk("R4 sw summary", new_summary_o, 32'h0000_0080);
        chk("R6 sw take", take_o, 1);
        pc_low_i = 2'b10; #1;
        chk("R5 misaligned", take_o, 0);
        pc_low_i = 2'b00; cur_ipl_i = 7; #1;
        chk("R6 equal level", take_o, 0);
        cur_ipl_i = 6; #1;
        chk("R6 above level", take_o, 1);
        cycle();
        post(17, 1); cycle(); idle(); #1;
        chk("R4 external wins", new_ipl_o, 17);
        chk("R4 merged summary", new_summary_o, 32'h0002_0080);
        clr(17, 1); cycle(); idle();
        clr(3, 0); cycle(); idle(); #1;
        chk("R5 nothing pending", take_o, 0);
        cur_ipl_i = 0;

        // R9: out-of-range level dropped
        sw_req_i = 15'h0004;
        post(40, 1); cycle(); idle(); #1;
        chk("R9 post dropped", take_o, 0);
        sw_req_i = 0;

        // R10: post beats clear on the same bit
        post(25, 4); clr(25, 4); cycle(); idle(); #1;
        chk("R10 post wins", new_summary_o[25], 1);

        // R3: clear-all beats post
        post(30, 2); clr_all_i = 1; cycle(); idle(); #1;
        chk("R3 all cleared", new_summary_o, 0);
        chk("R3 no take", take_o, 0);

        // R8: empty any latch, then commit with nothing latched
        commit_i = 1; cycle();
        commit_i = 1; cycle(); idle(); #1;
        chk("R8 reject", commit_err_o, 1);

        // Random traffic compared against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            idle();
            if ($urandom % 2 == 0) post(($urandom % 8) * 5, $urandom % 4);
            if ($urandom % 3 == 0) clr(($urandom % 8) * 5, $urandom % 4);
            clr_all_i = ($urandom % 40 == 0);
            commit_i  = ($urandom % 4 == 0);
            sw_req_i  = ($urandom % 4 == 0) ? 15'($urandom) : 15'h0;
            cur_ipl_i = 5'($urandom);
            pc_low_i  = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
            if ($urandom % 500 == 0) rst_n = 0; else rst_n = 1;
            cycle();
        end
        idle(); rst_n = 1; cycle();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule